// File: doc/BRIEF.md
# Addressed Slave Command Packet Engine

This block is one slave node on a shared half-duplex serial bus. A UART receiver hands it one byte at a time. From that stream it assembles fixed-length ASCII command packets and verifies their one-byte check field. If the packet names this node, it either reports the state of two digital inputs or updates two digital outputs. It then returns a fixed-length answer packet one byte at a time to a UART transmitter.

The node also owns the enable of the bus line driver. The enable is raised only while its own answer is leaving the transmitter. At all other times the line is left free for the master and the other slaves. The node identity is a binary value from 0 to 9 on `node_id`. On the wire it appears as the ASCII digit `'0'`..`'9'`.

Top module: `slave_pkt_engine`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `dout` is 2'b00 and both `drive_en` and `tx_valid` are 0.
- R2: A command packet is seven bytes in this order: STX 0x02, opcode, address, Data1, Data2, check, EOT 0x04. The check byte is the XOR of opcode, address, Data1 and Data2. A good read command (opcode 0x49 'I') addressed to this node is answered with STX, ACK 0x06, own address digit, Data1, Data2, check, EOT. Data1 is `din[0]` and Data2 is `din[1]`, each as ASCII 0x30/0x31, sampled through the input synchronizer. The read command's own data bytes are ignored.
- R3: A good write command (opcode 0x4F 'O') sets `dout[0]` from Data1 and `dout[1]` from Data2. Each data byte is 0x30 (drive low), 0x31 (drive high) or 0x54 'T' (invert the present value). The ACK carries the new output states as ASCII digits.
- R4: A packet addressed to this node whose check byte is wrong is answered with NAK 0x15, the own address and Data1 = Data2 = 0x30. The outputs do not change.
- R5: A packet whose address is not this node's digit gets no answer and changes no output, whether its check byte is right or wrong.
- R6: An STX byte received at any position restarts framing, and the partial packet before it is discarded.
- R7: If the seventh byte is not EOT, the packet is dropped with no answer. Bytes after it are ignored until the next STX.
- R8: A correctly checked, addressed packet with an opcode other than 'I'/'O', or a write whose data byte is not '0', '1' or 'T', gets a NAK and leaves the outputs unchanged.
- R9: `drive_en` rises in the same cycle the first answer byte (STX) is offered. It stays high until the transmitter reports idle after the last byte has been taken. It is low whenever no answer is in progress.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold their values.
- R11: Bytes received while an answer is being sent are ignored, so no command is acted on in that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| node_id | input | ID_W | This node's address, binary 0..9 |
| rx_data | input | 8 | Received byte from the UART |
| rx_valid | input | 1 | One-cycle strobe that `rx_data` is a new byte |
| tx_data | output | 8 | Answer byte offered to the UART transmitter |
| tx_valid | output | 1 | `tx_data` is valid |
| tx_ready | input | 1 | Transmitter takes the byte on this edge when high together with `tx_valid` |
| tx_idle | input | 1 | Transmitter has nothing left to shift out |
| din | input | 2 | Digital inputs reported by read commands |
| dout | output | 2 | Digital outputs set by write commands |
| drive_en | output | 1 | Bus line-driver enable |

## Verification
The bench targets the toggle code applied to both outputs and to one output at a time. A design that toggled the wrong bit, or wrote 'T' literally, would answer with wrong digits and leave `dout` wrong. It sends corrupted check bytes to this node and to another node. A design that answered before matching the address would put a NAK on the bus it does not own. Restart by a second STX, a missing EOT, and a full command arriving while an answer is being shifted out are each followed by a packet whose answer is known. A parser that lost sync, or acted on bytes during its own answer, would then give a wrong reply or wrong outputs. The transmitter model stalls `tx_ready` for several cycles per byte. A cycle-by-cycle monitor catches an enable that drops while the last byte is still shifting.

// File: rtl/slave_pkt_pkg.sv
package slave_pkt_pkg;
  localparam int BYTE_W    = 8;
  localparam int FRAME_LEN = 7;
  localparam int BODY_LEN  = 4;

  localparam logic [BYTE_W-1:0] CH_STX  = 8'h02;
  localparam logic [BYTE_W-1:0] CH_EOT  = 8'h04;
  localparam logic [BYTE_W-1:0] CH_ACK  = 8'h06;
  localparam logic [BYTE_W-1:0] CH_NAK  = 8'h15;
  localparam logic [BYTE_W-1:0] CH_RD   = 8'h49;
  localparam logic [BYTE_W-1:0] CH_WR   = 8'h4F;
  localparam logic [BYTE_W-1:0] CH_ZERO = 8'h30;
  localparam logic [BYTE_W-1:0] CH_ONE  = 8'h31;
  localparam logic [BYTE_W-1:0] CH_TGL  = 8'h54;

  typedef struct packed {
    logic [BYTE_W-1:0] op;
    logic [BYTE_W-1:0] addr;
    logic [BYTE_W-1:0] d1;
    logic [BYTE_W-1:0] d2;
  } body_t;

  function automatic logic [BYTE_W-1:0] body_sum(input body_t b);
    return b.op ^ b.addr ^ b.d1 ^ b.d2;
  endfunction

  function automatic logic [BYTE_W-1:0] bit_char(input logic v);
    return v ? CH_ONE : CH_ZERO;
  endfunction
endpackage

// File: rtl/slave_pkt_rx_framer.sv
module slave_pkt_rx_framer
  import slave_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              pkt_valid,
  output body_t             pkt_body,
  output logic              pkt_chk_ok
);
  localparam int POS_W   = $clog2(FRAME_LEN);
  localparam int CHK_POS = BODY_LEN;
  localparam int EOT_POS = BODY_LEN + 1;

  logic                         in_frame;
  logic [POS_W-1:0]             pos;
  logic [BYTE_W-1:0]            sum;
  logic [BODY_LEN-1:0][BYTE_W-1:0] held;
  logic                         chk_ok_q;
  logic                         take;

  assign take = rx_valid && accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame  <= 1'b0;
      pos       <= '0;
      sum       <= '0;
      held      <= '0;
      chk_ok_q  <= 1'b0;
      pkt_valid <= 1'b0;
      pkt_chk_ok <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      if (take) begin
        if (rx_data == CH_STX) begin
          in_frame <= 1'b1;
          pos      <= '0;
          sum      <= '0;
        end else if (in_frame) begin
          if (int'(pos) < BODY_LEN) begin
            held[BODY_LEN-1-int'(pos)] <= rx_data;
            sum <= sum ^ rx_data;
            pos <= pos + 1'b1;
          end else if (int'(pos) == CHK_POS) begin
            chk_ok_q <= (sum == rx_data);
            pos      <= pos + 1'b1;
          end else if (int'(pos) == EOT_POS) begin
            in_frame <= 1'b0;
            if (rx_data == CH_EOT) begin
              pkt_valid  <= 1'b1;
              pkt_chk_ok <= chk_ok_q;
            end
          end
        end
      end
    end
  end

  assign pkt_body = body_t'(held);
endmodule

// File: rtl/slave_pkt_exec.sv
module slave_pkt_exec
  import slave_pkt_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [ID_W-1:0] node_id,
  input  logic [1:0]      din_s,
  input  logic            pkt_valid,
  input  body_t           pkt_body,
  input  logic            pkt_chk_ok,
  output logic [1:0]      dout,
  output logic            rep_start,
  output body_t           rep_body
);
  localparam int MAX_ID = 9;

  logic [BYTE_W-1:0] own_char;
  logic              id_ok, hit, is_rd, is_wr, d_ok, good;
  logic [1:0]        nxt_out;

  function automatic logic char_ok(input logic [BYTE_W-1:0] c);
    return (c == CH_ZERO) || (c == CH_ONE) || (c == CH_TGL);
  endfunction

  function automatic logic apply(input logic [BYTE_W-1:0] c, input logic cur);
    if (c == CH_TGL) return ~cur;
    return (c == CH_ONE);
  endfunction

  always_comb begin
    id_ok    = (int'(node_id) <= MAX_ID);
    own_char = CH_ZERO + BYTE_W'(node_id);
    hit      = pkt_valid && id_ok && (pkt_body.addr == own_char);
    is_rd    = (pkt_body.op == CH_RD);
    is_wr    = (pkt_body.op == CH_WR);
    d_ok     = char_ok(pkt_body.d1) && char_ok(pkt_body.d2);
    good     = pkt_chk_ok && (is_rd || (is_wr && d_ok));
    nxt_out  = {apply(pkt_body.d2, dout[1]), apply(pkt_body.d1, dout[0])};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout      <= 2'b00;
      rep_start <= 1'b0;
      rep_body  <= '0;
    end else begin
      rep_start <= hit;
      if (hit) begin
        rep_body.addr <= own_char;
        if (!good) begin
          rep_body.op <= CH_NAK;
          rep_body.d1 <= CH_ZERO;
          rep_body.d2 <= CH_ZERO;
        end else if (is_rd) begin
          rep_body.op <= CH_ACK;
          rep_body.d1 <= bit_char(din_s[0]);
          rep_body.d2 <= bit_char(din_s[1]);
        end else begin
          rep_body.op <= CH_ACK;
          rep_body.d1 <= bit_char(nxt_out[0]);
          rep_body.d2 <= bit_char(nxt_out[1]);
          dout        <= nxt_out;
        end
      end
    end
  end
endmodule

// File: rtl/slave_pkt_reply_tx.sv
module slave_pkt_reply_tx
  import slave_pkt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rep_start,
  input  body_t             rep_body,
  input  logic              tx_ready,
  input  logic              tx_idle,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  output logic              drive_en,
  output logic              busy
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(FRAME_LEN - 1);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_GUARD, S_DRAIN} st_t;

  st_t               st;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  idx_nxt;
  logic [BYTE_W-1:0] frm [FRAME_LEN];
  logic [BYTE_W-1:0] fill [FRAME_LEN];

  assign idx_nxt = idx + 1'b1;
  assign busy    = (st != S_IDLE);

  always_comb begin
    fill[0] = CH_STX;
    fill[1] = rep_body.op;
    fill[2] = rep_body.addr;
    fill[3] = rep_body.d1;
    fill[4] = rep_body.d2;
    fill[5] = body_sum(rep_body);
    fill[6] = CH_EOT;
  end

  always_ff @(posedge clk) begin
    if (rep_start && st == S_IDLE) begin
      for (int i = 0; i < FRAME_LEN; i++) frm[i] <= fill[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      idx      <= '0;
      tx_data  <= '0;
      tx_valid <= 1'b0;
      drive_en <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (rep_start) begin
          st       <= S_SEND;
          idx      <= '0;
          tx_data  <= CH_STX;
          tx_valid <= 1'b1;
          drive_en <= 1'b1;
        end
        S_SEND: if (tx_ready) begin
          if (idx == LAST) begin
            tx_valid <= 1'b0;
            st       <= S_GUARD;
          end else begin
            idx     <= idx_nxt;
            tx_data <= frm[idx_nxt];
          end
        end
        S_GUARD: st <= S_DRAIN;
        S_DRAIN: if (tx_idle) begin
          drive_en <= 1'b0;
          st       <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/slave_pkt_engine.sv
module slave_pkt_engine
  import slave_pkt_pkg::*;
#(
  parameter int ID_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ID_W-1:0]   node_id,
  input  logic [7:0]        rx_data,
  input  logic              rx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  input  logic              tx_idle,
  input  logic [1:0]        din,
  output logic [1:0]        dout,
  output logic              drive_en
);
  logic  [1:0] din_s;
  logic        pkt_valid, pkt_chk_ok, rep_start, tx_busy;
  body_t       pkt_body, rep_body;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign din_s = din;
    end else begin : g_sync
      logic [1:0] sr [SYNC_STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < SYNC_STAGES; i++) sr[i] <= 2'b00;
        end else begin
          sr[0] <= din;
          for (int i = 1; i < SYNC_STAGES; i++) sr[i] <= sr[i-1];
        end
      end
      assign din_s = sr[SYNC_STAGES-1];
    end
  endgenerate

  slave_pkt_rx_framer u_framer (
    .clk(clk), .rst(rst), .accept(!tx_busy),
    .rx_data(rx_data), .rx_valid(rx_valid),
    .pkt_valid(pkt_valid), .pkt_body(pkt_body), .pkt_chk_ok(pkt_chk_ok)
  );

  slave_pkt_exec #(.ID_W(ID_W)) u_exec (
    .clk(clk), .rst(rst), .node_id(node_id), .din_s(din_s),
    .pkt_valid(pkt_valid), .pkt_body(pkt_body), .pkt_chk_ok(pkt_chk_ok),
    .dout(dout), .rep_start(rep_start), .rep_body(rep_body)
  );

  slave_pkt_reply_tx u_reply (
    .clk(clk), .rst(rst), .rep_start(rep_start), .rep_body(rep_body),
    .tx_ready(tx_ready), .tx_idle(tx_idle),
    .tx_data(tx_data), .tx_valid(tx_valid), .drive_en(drive_en), .busy(tx_busy)
  );
endmodule

// File: rtl/slave_pkt_engine_chk.sv
module slave_pkt_engine_chk
  import slave_pkt_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [7:0]  tx_data,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic        tx_idle,
  input logic [1:0]  dout,
  input logic        drive_en,
  input logic        rep_start,
  input body_t       rep_body
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data)); // R10

  AST_TX_UNDER_EN: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> drive_en); // R9

  AST_EN_OPENS_STX: assert property (@(posedge clk) disable iff (rst)
    $rose(drive_en) |-> tx_valid && tx_data == CH_STX); // R9

  AST_EN_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_en) |-> $past(tx_idle) && !tx_valid); // R9

  AST_DOUT_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(dout) |-> rep_start && rep_body.op == CH_ACK); // R3

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    rep_start |-> !drive_en); // R11

  always @(posedge clk) begin
    if (rst) begin
      AST_RESET_QUIET: assert (dout == 2'b00 || $past(rst) == 1'b0); // R1
    end
  end
endmodule

bind slave_pkt_engine slave_pkt_engine_chk chk_i (
  .clk(clk), .rst(rst), .tx_data(tx_data), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .tx_idle(tx_idle), .dout(dout), .drive_en(drive_en),
  .rep_start(rep_start), .rep_body(rep_body)
);

// File: tb/slave_pkt_engine_test.sv
module slave_pkt_engine_test;
  localparam int CLK_P = 10;
  localparam int SHIFT = 6;
  localparam int NV    = 12;
  localparam logic [7:0] ME = 8'h35;

  typedef struct packed {
    logic [7:0] op, ad, d1, d2;
    logic       bad;
    logic [1:0] din;
    logic       rep;
    logic [7:0] eop, e1, e2;
    logic [1:0] edo;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{8'h49, 8'h35, 8'h30, 8'h30, 1'b0, 2'b10, 1'b1, 8'h06, 8'h30, 8'h31, 2'b00},
    '{8'h4F, 8'h35, 8'h31, 8'h30, 1'b0, 2'b10, 1'b1, 8'h06, 8'h31, 8'h30, 2'b01},
    '{8'h4F, 8'h35, 8'h54, 8'h54, 1'b0, 2'b10, 1'b1, 8'h06, 8'h30, 8'h31, 2'b10},
    '{8'h4F, 8'h33, 8'h31, 8'h31, 1'b0, 2'b10, 1'b0, 8'h00, 8'h00, 8'h00, 2'b10},
    '{8'h4F, 8'h35, 8'h31, 8'h31, 1'b1, 2'b10, 1'b1, 8'h15, 8'h30, 8'h30, 2'b10},
    '{8'h4F, 8'h37, 8'h31, 8'h31, 1'b1, 2'b10, 1'b0, 8'h00, 8'h00, 8'h00, 2'b10},
    '{8'h58, 8'h35, 8'h30, 8'h30, 1'b0, 2'b10, 1'b1, 8'h15, 8'h30, 8'h30, 2'b10},
    '{8'h4F, 8'h35, 8'h54, 8'h32, 1'b0, 2'b10, 1'b1, 8'h15, 8'h30, 8'h30, 2'b10},
    '{8'h49, 8'h35, 8'h30, 8'h30, 1'b0, 2'b01, 1'b1, 8'h06, 8'h31, 8'h30, 2'b10},
    '{8'h4F, 8'h35, 8'h30, 8'h54, 1'b0, 2'b01, 1'b1, 8'h06, 8'h30, 8'h30, 2'b00},
    '{8'h4F, 8'h35, 8'h31, 8'h31, 1'b0, 2'b01, 1'b1, 8'h06, 8'h31, 8'h31, 2'b11},
    '{8'h49, 8'h39, 8'h30, 8'h30, 1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 8'h00, 2'b11}
  };

  logic       clk = 0, rst = 1;
  logic [3:0] node_id = 4'd5;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 0;
  logic [7:0] tx_data;
  logic       tx_valid, tx_ready, tx_idle, drive_en;
  logic [1:0] din = 2'b00, dout;

  int unsigned busy_m;
  logic [7:0]  cap [16];
  int          cap_n;
  logic        cap_clr = 0;
  int          n_chk = 0, n_fail = 0, en_err = 0;
  logic        done = 0;

  always #(CLK_P/2) clk = ~clk;

  slave_pkt_engine uut (
    .clk(clk), .rst(rst), .node_id(node_id), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_idle(tx_idle),
    .din(din), .dout(dout), .drive_en(drive_en)
  );

  assign tx_ready = (busy_m == 0);
  assign tx_idle  = (busy_m == 0);

  always @(posedge clk) begin
    if (rst) begin
      busy_m <= 0;
      cap_n  <= 0;
    end else begin
      if (tx_valid && tx_ready) begin
        busy_m <= SHIFT;
        if (cap_n < 16) cap[cap_n] <= tx_data;
        cap_n <= cap_clr ? 0 : cap_n + 1;
      end else begin
        if (busy_m != 0) busy_m <= busy_m - 1;
        if (cap_clr) cap_n <= 0;
      end
    end
  end

  // R9 monitor: line driver must be on while a byte shifts or is offered
  always @(negedge clk) begin
    if (!rst && ((busy_m != 0) || tx_valid) && !drive_en) en_err++;
  end

  task automatic check(input logic ok, input string req, input int act, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk); rx_data = b; rx_valid = 1;
    @(negedge clk); rx_valid = 0;
  endtask

  task automatic send_pkt(input logic [7:0] op, ad, d1, d2, input logic bad);
    logic [7:0] c;
    c = op ^ ad ^ d1 ^ d2 ^ (bad ? 8'hFF : 8'h00);
    send_byte(8'h02); send_byte(op); send_byte(ad);
    send_byte(d1); send_byte(d2); send_byte(c); send_byte(8'h04);
  endtask

  task automatic clear_cap();
    @(negedge clk); cap_clr = 1;
    @(negedge clk); cap_clr = 0;
  endtask

  task automatic expect_reply(input string req, input logic [7:0] op, e1, e2);
    logic [7:0] exp_b [7];
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (cap_n >= 7 && !drive_en) break;
    end
    exp_b = '{8'h02, op, ME, e1, e2, op ^ ME ^ e1 ^ e2, 8'h04};
    check(cap_n == 7, {req, " reply length"}, cap_n, 7);
    for (int i = 0; i < 7; i++)
      check(cap[i] == exp_b[i], {req, " reply byte"}, cap[i], exp_b[i]);
  endtask

  task automatic expect_silent(input string req);
    repeat (80) @(negedge clk);
    check(cap_n == 0, {req, " no reply"}, cap_n, 0);
    check(drive_en == 1'b0, {req, " driver released"}, drive_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(dout == 2'b00 && !drive_en && !tx_valid, "R1 in reset", {dout, drive_en, tx_valid}, 0);
    rst = 0;
    @(negedge clk);
    check(dout == 2'b00 && !drive_en && !tx_valid, "R1 after reset", {dout, drive_en, tx_valid}, 0);

    // table: R2 R3 R4 R5 R8
    for (int v = 0; v < NV; v++) begin
      din = VEC[v].din;
      clear_cap();
      send_pkt(VEC[v].op, VEC[v].ad, VEC[v].d1, VEC[v].d2, VEC[v].bad);
      if (VEC[v].rep) expect_reply($sformatf("R2/R3/R4/R8 vec%0d", v), VEC[v].eop, VEC[v].e1, VEC[v].e2);
      else expect_silent($sformatf("R5 vec%0d", v));
      check(dout == VEC[v].edo, $sformatf("R3 dout vec%0d", v), dout, VEC[v].edo);
    end

    // R6: second STX restarts framing
    clear_cap();
    send_byte(8'h02); send_byte(8'h4F); send_byte(8'h35);
    send_pkt(8'h4F, 8'h35, 8'h30, 8'h30, 1'b0);
    expect_reply("R6 restart", 8'h06, 8'h30, 8'h30);
    check(dout == 2'b00, "R6 dout", dout, 0);

    // R7: wrong seventh byte drops packet, stray bytes ignored
    clear_cap();
    send_byte(8'h02); send_byte(8'h4F); send_byte(8'h35); send_byte(8'h31);
    send_byte(8'h31); send_byte(8'h4F ^ 8'h35); send_byte(8'h58); send_byte(8'h04);
    expect_silent("R7 missing EOT");
    check(dout == 2'b00, "R7 dout", dout, 0);
    din = 2'b01;
    clear_cap();
    send_pkt(8'h49, 8'h35, 8'h30, 8'h30, 1'b0);
    expect_reply("R7 recovery", 8'h06, 8'h31, 8'h30);

    // R11: command arriving during own reply is ignored
    clear_cap();
    send_pkt(8'h49, 8'h35, 8'h30, 8'h30, 1'b0);
    for (int i = 0; i < 20 && !drive_en; i++) @(negedge clk);
    send_pkt(8'h4F, 8'h35, 8'h54, 8'h54, 1'b0);
    expect_reply("R11 single reply", 8'h06, 8'h31, 8'h30);
    repeat (80) @(negedge clk);
    check(cap_n == 7, "R11 no second reply", cap_n, 7);
    check(dout == 2'b00, "R11 dout unchanged", dout, 0);

    // R9: driver enable followed every shifted byte
    check(en_err == 0, "R9 enable coverage", en_err, 0);

    // R1: reset in mid-operation
    clear_cap();
    send_pkt(8'h4F, 8'h35, 8'h31, 8'h31, 1'b0);
    expect_reply("R3 set both", 8'h06, 8'h31, 8'h31);
    check(dout == 2'b11, "R3 dout both high", dout, 3);
    rst = 1;
    @(negedge clk); @(negedge clk);
    check(dout == 2'b00 && !drive_en && !tx_valid, "R1 re-reset", {dout, drive_en, tx_valid}, 0);
    rst = 0;

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule